// File: doc/BRIEF.md
# Virtually Addressed Data Cache with Process Tags

This block is a direct-mapped data cache that is indexed and tagged with virtual addresses, so a hit needs no address translation. Each line records the process identifier that filled it. A hit needs three things: the line is valid, its virtual tag matches, and its stored identifier equals the current one. Lines that belong to different processes can therefore stay resident together. The current identifier is loaded through a small context-switch handshake. Only a miss goes to the translation port. The cache sends the virtual page number and the current identifier, receives a physical page number, and then reads the whole line from physical memory. Each line also keeps the physical page it was filled from, so a write hit can be sent through to memory without a second translation.

The parameter `PURGE_MODE` selects a second way of handling process switches. When it is set, the identifier is not compared. Instead, every switch to a different identifier clears all valid bits in a single stall cycle. Both approaches can then be measured on the same traffic. After a purge, every access misses until refills bring lines back.

The request, response, translation and memory-port streams use valid/ready handshakes. A valid signal stays high, with a stable payload, until it meets ready. The cache takes one request or one context switch at a time and only while idle. A context switch has priority over a request offered in the same cycle. A response is held until `rsp_ready`. The translation response and the line-read response have no back-pressure: the cache is always waiting for them when they arrive.

Top module: `vcache_pid`

## Requirements
- R1: A read whose line is valid, whose tag (address bits above index and offset) matches, and, when `PURGE_MODE`=0, whose stored identifier equals the current one, is a hit. It raises `rsp_valid` with `rsp_hit`=1 in the cycle after acceptance and makes no translation request.
- R2: A read miss puts the virtual page number (address bits above the page offset) and the current identifier on the translation port. It waits for the physical page, then reads the line at {page, address[page offset-1 : line offset], zero offset}. It installs that line with its tag, the current identifier and the page. It returns word address[3:2] of the line (line bits [32*w +: 32]) with `rsp_hit`=0.
- R3: When `PURGE_MODE`=0, a context switch invalidates nothing. A line hits only for the identifier that filled it, and lines of different identifiers at different indices coexist.
- R4: When `PURGE_MODE`=1, a context switch to a different identifier clears every valid bit. For the one cycle after it is accepted, `req_ready` and `ctx_ready` are low. A switch to the identifier already current causes neither a purge nor a stall.
- R5: After a purge, every access misses until its line has been refilled.
- R6: A write hit updates its word in the line. It writes the word through to memory at {stored page, address[page offset-1:2], 2'b00}, reports `rsp_hit`=1 and makes no translation request.
- R7: A write miss allocates nothing. It translates, then writes the word to memory at the translated address. The line held at that index is unchanged.
- R8: The index is address bits [line offset +: log2(LINES)] (bits [9:4] by default). A read miss at an index replaces the line held there, even when that line had a different tag.
- R9: Outbound valid signals hold with stable payload until ready. At most one of the translation request, line read, memory write and response is active in any cycle. `req_ready` is low while a request is in progress.
- R10: Reset leaves every line invalid and the current identifier at zero. After reset, `req_ready` is high and no outbound valid signal is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_valid | input | 1 | Context-switch request |
| ctx_ready | output | 1 | Cache can take a context switch |
| ctx_pid | input | PID_W | New process identifier |
| req_valid | input | 1 | CPU access request |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Virtual byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Access response |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_rdata | output | DATA_W | Read data (meaningless for writes) |
| rsp_hit | output | 1 | Access hit in the cache |
| tr_req_valid | output | 1 | Translation request |
| tr_req_ready | input | 1 | Translator takes the request |
| tr_req_vpn | output | ADDR_W-log2(PAGE_BYTES) | Virtual page number |
| tr_req_pid | output | PID_W | Identifier for the translation |
| tr_rsp_valid | input | 1 | Translation result |
| tr_rsp_ppn | input | ADDR_W-log2(PAGE_BYTES) | Physical page number |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory takes the line read |
| mem_rd_addr | output | ADDR_W | Physical line address |
| mem_rd_rvalid | input | 1 | Line data returned |
| mem_rd_rdata | input | LINE_BYTES*8 | Line data, word w at bits [32*w +: 32] |
| mem_wr_valid | output | 1 | Write-through request |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_addr | output | ADDR_W | Physical word address |
| mem_wr_data | output | DATA_W | Write data |

## Verification
The assertions check the stream rules on every cycle. These are: payload holding under back-pressure, one outbound transaction at a time, the identifier sent with each translation, the one-cycle response of a read hit, and the stall that follows a purging switch. Other behaviour depends on history, and only the bench's scenarios can show it. This covers whether lines of two identifiers coexist or are lost to a purge, and whether a switch to the same identifier purges. It also covers replacement on a tag conflict, and the fact that a write miss leaves the resident line intact. The bench checks all of this against a reference model of valid bits, tags and identifiers, for both settings of `PURGE_MODE`.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PURGE,
    ST_TREQ,
    ST_TWAIT,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRREQ,
    ST_RESP
  } vc_state_e;
endpackage

// File: rtl/vcache_tagstore.sv
module vcache_tagstore #(
  parameter int LINES      = 64,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 22,
  parameter int PID_W      = 8,
  parameter int PPN_W      = 20,
  parameter bit PURGE_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             clear_all
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [PID_W-1:0] pid_q [LINES];
  logic [PPN_W-1:0] ppn_q [LINES];
  logic             pid_ok;

  // valid bits are the only state that needs a reset value
  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) valid_q <= '0;
    else if (fill_en)        valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      pid_q[fill_idx] <= fill_pid;
      ppn_q[fill_idx] <= fill_ppn;
    end
  end

  // the parameter picks whether the identifier takes part in the compare
  generate
    if (PURGE_MODE) begin : g_no_pid
      assign pid_ok = 1'b1;
    end else begin : g_pid_cmp
      assign pid_ok = (pid_q[lk_idx] == lk_pid);
    end
  endgenerate

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && pid_ok;
  assign lk_ppn = ppn_q[lk_idx];
endmodule

// File: rtl/vcache_datastore.sv
module vcache_datastore #(
  parameter int LINES  = 64,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int WSEL_W = 2,
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_word
);
  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (fill_en)    line_q[fill_idx] <= fill_line;
    else if (wr_en) line_q[wr_idx][wr_sel*DATA_W +: DATA_W] <= wr_data;
  end

  assign rd_word = line_q[rd_idx][rd_sel*DATA_W +: DATA_W];
endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PID_W      = 8,
  parameter int OFF_W      = 4,
  parameter int IDX_W      = 6,
  parameter int PAGE_W     = 12,
  parameter int WSEL_W     = 2,
  parameter int BSEL_W     = 2,
  parameter int LINE_W     = 128,
  parameter bit PURGE_MODE = 1'b0,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int PPN_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_valid,
  output logic              ctx_ready,
  input  logic [PID_W-1:0]  ctx_pid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              tr_req_valid,
  input  logic              tr_req_ready,
  output logic [PPN_W-1:0]  tr_req_vpn,
  output logic [PID_W-1:0]  tr_req_pid,
  input  logic              tr_rsp_valid,
  input  logic [PPN_W-1:0]  tr_rsp_ppn,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_rvalid,
  input  logic [LINE_W-1:0] mem_rd_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              lk_hit,
  input  logic [PPN_W-1:0]  lk_ppn,
  input  logic [DATA_W-1:0] rd_word,
  output logic [PID_W-1:0]  cur_pid,
  output logic              wr_en,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              clear_all
);
  vc_state_e          state_q;
  logic [ADDR_W-1:0]  a_q;
  logic [DATA_W-1:0]  wd_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [PPN_W-1:0]   ppn_q;
  logic               wr_q;
  logic               hit_q;
  logic               idle;
  logic               ctx_take;
  logic               req_take;
  logic [WSEL_W-1:0]  sel_q;

  assign idle     = (state_q == ST_IDLE);
  assign ctx_ready = idle;
  assign req_ready = idle && !ctx_valid;
  assign ctx_take = ctx_valid && ctx_ready;
  assign req_take = req_valid && req_ready;
  assign sel_q    = a_q[OFF_W-1:BSEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_pid <= '0;
      a_q     <= '0;
      wd_q    <= '0;
      rdata_q <= '0;
      ppn_q   <= '0;
      wr_q    <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ctx_take) begin
            cur_pid <= ctx_pid;
            if (PURGE_MODE && (ctx_pid != cur_pid)) state_q <= ST_PURGE;
          end else if (req_take) begin
            a_q   <= req_addr;
            wd_q  <= req_wdata;
            wr_q  <= req_write;
            hit_q <= lk_hit;
            ppn_q <= lk_ppn;
            rdata_q <= rd_word;
            if (lk_hit) state_q <= req_write ? ST_WRREQ : ST_RESP;
            else        state_q <= ST_TREQ;
          end
        end
        ST_PURGE: state_q <= ST_IDLE;
        ST_TREQ:  if (tr_req_ready) state_q <= ST_TWAIT;
        ST_TWAIT: begin
          if (tr_rsp_valid) begin
            ppn_q   <= tr_rsp_ppn;
            state_q <= wr_q ? ST_WRREQ : ST_RDREQ;
          end
        end
        ST_RDREQ: if (mem_rd_ready) state_q <= ST_RDWAIT;
        ST_RDWAIT: begin
          if (mem_rd_rvalid) begin
            rdata_q <= mem_rd_rdata[sel_q*DATA_W +: DATA_W];
            state_q <= ST_RESP;
          end
        end
        ST_WRREQ: if (mem_wr_ready) state_q <= ST_RESP;
        ST_RESP:  if (rsp_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage side effects
  assign wr_en     = req_take && req_write && lk_hit;
  assign fill_en   = (state_q == ST_RDWAIT) && mem_rd_rvalid;
  assign fill_idx  = a_q[OFF_W +: IDX_W];
  assign fill_tag  = a_q[ADDR_W-1 -: TAG_W];
  assign fill_ppn  = ppn_q;
  assign clear_all = (state_q == ST_PURGE);

  // outbound streams
  assign tr_req_valid = (state_q == ST_TREQ);
  assign tr_req_vpn   = a_q[ADDR_W-1 -: PPN_W];
  assign tr_req_pid   = cur_pid;
  assign mem_rd_valid = (state_q == ST_RDREQ);
  assign mem_rd_addr  = {ppn_q, a_q[PAGE_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wr_valid = (state_q == ST_WRREQ);
  assign mem_wr_addr  = {ppn_q, a_q[PAGE_W-1:BSEL_W], {BSEL_W{1'b0}}};
  assign mem_wr_data  = wd_q;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_hit      = hit_q;
endmodule

// File: rtl/vcache_pid.sv
module vcache_pid #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 64,
  parameter int PID_W      = 8,
  parameter int PAGE_BYTES = 4096,
  parameter bit PURGE_MODE = 1'b0,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int PPN_W  = ADDR_W - PAGE_W,
  localparam int WORDS  = LINE_BYTES * 8 / DATA_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(DATA_W / 8),
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_valid,
  output logic              ctx_ready,
  input  logic [PID_W-1:0]  ctx_pid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              tr_req_valid,
  input  logic              tr_req_ready,
  output logic [PPN_W-1:0]  tr_req_vpn,
  output logic [PID_W-1:0]  tr_req_pid,
  input  logic              tr_rsp_valid,
  input  logic [PPN_W-1:0]  tr_rsp_ppn,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_rvalid,
  input  logic [LINE_W-1:0] mem_rd_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WSEL_W-1:0] lk_sel;
  logic              lk_hit;
  logic [PPN_W-1:0]  lk_ppn;
  logic [DATA_W-1:0] rd_word;
  logic [PID_W-1:0]  cur_pid;
  logic              wr_en;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [PPN_W-1:0]  fill_ppn;
  logic              clear_all;

  assign lk_idx = req_addr[OFF_W +: IDX_W];
  assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_sel = req_addr[OFF_W-1:BSEL_W];

  vcache_tagstore #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PID_W(PID_W),
    .PPN_W(PPN_W), .PURGE_MODE(PURGE_MODE)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_pid(cur_pid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_pid(cur_pid), .fill_ppn(fill_ppn), .clear_all(clear_all)
  );

  vcache_datastore #(
    .LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W), .WORDS(WORDS), .WSEL_W(WSEL_W)
  ) u_data (
    .clk(clk),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(mem_rd_rdata),
    .wr_en(wr_en), .wr_idx(lk_idx), .wr_sel(lk_sel), .wr_data(req_wdata),
    .rd_idx(lk_idx), .rd_sel(lk_sel), .rd_word(rd_word)
  );

  vcache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PID_W(PID_W), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .PAGE_W(PAGE_W), .WSEL_W(WSEL_W), .BSEL_W(BSEL_W),
    .LINE_W(LINE_W), .PURGE_MODE(PURGE_MODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctx_valid(ctx_valid), .ctx_ready(ctx_ready), .ctx_pid(ctx_pid),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .tr_req_valid(tr_req_valid), .tr_req_ready(tr_req_ready),
    .tr_req_vpn(tr_req_vpn), .tr_req_pid(tr_req_pid),
    .tr_rsp_valid(tr_rsp_valid), .tr_rsp_ppn(tr_rsp_ppn),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rd_word(rd_word),
    .cur_pid(cur_pid), .wr_en(wr_en), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_ppn(fill_ppn), .clear_all(clear_all)
  );
endmodule

// File: rtl/vcache_pid_chk.sv
module vcache_pid_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PID_W      = 8,
  parameter int PPN_W      = 20,
  parameter bit PURGE_MODE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctx_valid,
  input logic              ctx_ready,
  input logic [PID_W-1:0]  ctx_pid,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_hit,
  input logic              tr_req_valid,
  input logic              tr_req_ready,
  input logic [PPN_W-1:0]  tr_req_vpn,
  input logic [PID_W-1:0]  tr_req_pid,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              lk_hit,
  input logic [PID_W-1:0]  cur_pid
);
  a_r9_tr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req_valid && !tr_req_ready |=> tr_req_valid && $stable(tr_req_vpn) && $stable(tr_req_pid));

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit));

  a_r9_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tr_req_valid, mem_rd_valid, mem_wr_valid, rsp_valid}));

  a_r2_tr_pid: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req_valid |-> tr_req_pid == cur_pid);

  a_r1_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && lk_hit |=> rsp_valid && rsp_hit);

  a_r4_purge_stall: assert property (@(posedge clk) disable iff (!rst_n)
    PURGE_MODE && ctx_valid && ctx_ready && (ctx_pid != cur_pid) |=> !req_ready && !ctx_ready);
endmodule

bind vcache_pid vcache_pid_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PID_W(PID_W), .PPN_W(PPN_W), .PURGE_MODE(PURGE_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ctx_valid(ctx_valid), .ctx_ready(ctx_ready), .ctx_pid(ctx_pid),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
  .tr_req_valid(tr_req_valid), .tr_req_ready(tr_req_ready),
  .tr_req_vpn(tr_req_vpn), .tr_req_pid(tr_req_pid),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .lk_hit(lk_hit), .cur_pid(cur_pid)
);

// File: tb/vcache_pid_test.sv
module vcache_pid_test;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ctx_valid [2];
  logic        ctx_ready [2];
  logic [7:0]  ctx_pid   [2];
  logic        req_valid [2];
  logic        req_ready [2];
  logic        req_write [2];
  logic [31:0] req_addr  [2];
  logic [31:0] req_wdata [2];
  logic        rsp_valid [2];
  logic        rsp_ready [2];
  logic [31:0] rsp_rdata [2];
  logic        rsp_hit   [2];
  logic        tr_req_valid [2];
  logic [19:0] tr_req_vpn   [2];
  logic [7:0]  tr_req_pid   [2];
  logic        tr_rsp_valid [2];
  logic [19:0] tr_rsp_ppn   [2];
  logic        mem_rd_valid [2];
  logic [31:0] mem_rd_addr  [2];
  logic        mem_rd_rvalid [2];
  logic [127:0] mem_rd_rdata [2];
  logic        mem_wr_valid [2];
  logic [31:0] mem_wr_addr  [2];
  logic [31:0] mem_wr_data  [2];

  logic [31:0] memw [2][logic [31:0]];
  int          tr_cnt [2];
  int          wr_cnt [2];
  logic [19:0] last_vpn [2];
  logic [7:0]  last_tpid [2];
  logic [31:0] last_wa [2];
  logic [31:0] last_wd [2];

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model of the cache directory
  bit          mv [2][NL];
  logic [24:0] mt [2][NL];
  logic [7:0]  mp [2][NL];
  logic [7:0]  cur [2];

  for (genvar g = 0; g < 2; g++) begin : g_dut
    vcache_pid #(.LINES(NL), .PURGE_MODE(g == 1)) uut (
      .clk(clk), .rst_n(rst_n),
      .ctx_valid(ctx_valid[g]), .ctx_ready(ctx_ready[g]), .ctx_pid(ctx_pid[g]),
      .req_valid(req_valid[g]), .req_ready(req_ready[g]), .req_write(req_write[g]),
      .req_addr(req_addr[g]), .req_wdata(req_wdata[g]),
      .rsp_valid(rsp_valid[g]), .rsp_ready(rsp_ready[g]), .rsp_rdata(rsp_rdata[g]),
      .rsp_hit(rsp_hit[g]),
      .tr_req_valid(tr_req_valid[g]), .tr_req_ready(1'b1),
      .tr_req_vpn(tr_req_vpn[g]), .tr_req_pid(tr_req_pid[g]),
      .tr_rsp_valid(tr_rsp_valid[g]), .tr_rsp_ppn(tr_rsp_ppn[g]),
      .mem_rd_valid(mem_rd_valid[g]), .mem_rd_ready(1'b1), .mem_rd_addr(mem_rd_addr[g]),
      .mem_rd_rvalid(mem_rd_rvalid[g]), .mem_rd_rdata(mem_rd_rdata[g]),
      .mem_wr_valid(mem_wr_valid[g]), .mem_wr_ready(1'b1),
      .mem_wr_addr(mem_wr_addr[g]), .mem_wr_data(mem_wr_data[g])
    );
  end

  function automatic logic [19:0] xl(input logic [7:0] pid, input logic [19:0] vpn);
    return vpn ^ 20'hA5000 ^ {12'h0, pid};
  endfunction

  function automatic logic [31:0] memword(input int m, input logic [31:0] a);
    if (memw[m].exists(a)) return memw[m][a];
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  // translator and memory models
  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      tr_rsp_valid[m]  <= 1'b0;
      mem_rd_rvalid[m] <= 1'b0;
      if (rst_n && tr_req_valid[m]) begin
        tr_rsp_valid[m] <= 1'b1;
        tr_rsp_ppn[m]   <= xl(tr_req_pid[m], tr_req_vpn[m]);
        tr_cnt[m]    = tr_cnt[m] + 1;
        last_vpn[m]  = tr_req_vpn[m];
        last_tpid[m] = tr_req_pid[m];
      end
      if (rst_n && mem_rd_valid[m]) begin
        mem_rd_rvalid[m] <= 1'b1;
        for (int w = 0; w < 4; w++)
          mem_rd_rdata[m][w*32 +: 32] <= memword(m, mem_rd_addr[m] + 32'(w*4));
      end
      if (rst_n && mem_wr_valid[m]) begin
        memw[m][mem_wr_addr[m]] = mem_wr_data[m];
        wr_cnt[m]  = wr_cnt[m] + 1;
        last_wa[m] = mem_wr_addr[m];
        last_wd[m] = mem_wr_data[m];
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic ctx(input int m, input logic [7:0] p, input string rq);
    bit stall;
    stall = (m == 1) && (p != cur[m]);
    @(negedge clk);
    ctx_valid[m] = 1'b1;
    ctx_pid[m] = p;
    #1;
    while (!ctx_ready[m]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    ctx_valid[m] = 1'b0;
    #1;
    chk(rq, "req_ready after switch", 32'(req_ready[m]), 32'(!stall));
    chk(rq, "ctx_ready after switch", 32'(ctx_ready[m]), 32'(!stall));
    if (stall) for (int i = 0; i < NL; i++) mv[m][i] = 1'b0;
    cur[m] = p;
  endtask

  task automatic access(input int m, input bit wr, input logic [24:0] tg, input int idx,
                        input int w, input logic [31:0] wd, input string rq, input bit hold);
    logic [31:0] va;
    logic        eh;
    logic [31:0] pa;
    logic [31:0] expd;
    logic [31:0] hd;
    int tr0, wr0, lat;
    va   = {tg, 3'(idx), 2'(w), 2'b00};
    eh   = mv[m][idx] && (mt[m][idx] == tg) && (m == 1 || mp[m][idx] == cur[m]);
    pa   = {xl(cur[m], va[31:12]), va[11:2], 2'b00};
    expd = memword(m, pa);
    tr0  = tr_cnt[m];
    wr0  = wr_cnt[m];
    @(negedge clk);
    req_valid[m] = 1'b1;
    req_write[m] = wr;
    req_addr[m]  = va;
    req_wdata[m] = wd;
    #1;
    while (!req_ready[m]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid[m] = 1'b0;
    #1;
    chk({rq, "/R9"}, "req_ready while busy", 32'(req_ready[m]), 32'd0);
    lat = 1;
    while (!rsp_valid[m]) begin @(negedge clk); lat++; end
    if (hold) begin
      rsp_ready[m] = 1'b0;
      hd = rsp_rdata[m];
      @(negedge clk);
      @(negedge clk);
      chk("R9", "rsp_valid held", 32'(rsp_valid[m]), 32'd1);
      chk("R9", "rsp_rdata stable", rsp_rdata[m], hd);
      rsp_ready[m] = 1'b1;
    end
    chk({rq, eh ? "/R1" : "/R2"}, "hit flag", 32'(rsp_hit[m]), 32'(eh));
    if (!wr) begin
      chk(rq, "read data", rsp_rdata[m], expd);
      if (eh) begin
        chk("R1", "hit latency", 32'(lat), 32'd1);
        chk("R1", "no translation on hit", 32'(tr_cnt[m]), 32'(tr0));
      end else begin
        chk("R2", "one translation on miss", 32'(tr_cnt[m]), 32'(tr0 + 1));
        chk("R2", "translated page number", 32'(last_vpn[m]), 32'(va[31:12]));
        chk("R2", "translated pid", 32'(last_tpid[m]), 32'(cur[m]));
      end
    end else begin
      chk(eh ? "R6" : "R7", "write-through count", 32'(wr_cnt[m]), 32'(wr0 + 1));
      chk(eh ? "R6" : "R7", "write-through address", last_wa[m], pa);
      chk(eh ? "R6" : "R7", "write-through data", last_wd[m], wd);
      chk(eh ? "R6" : "R7", "translation count", 32'(tr_cnt[m]), 32'(tr0 + (eh ? 0 : 1)));
    end
    @(posedge clk);
    if (!wr && !eh) begin
      mv[m][idx] = 1'b1;
      mt[m][idx] = tg;
      mp[m][idx] = cur[m];
    end
  endtask

  localparam logic [24:0] TA = 25'h0ABCD;
  localparam logic [24:0] TB = 25'h1F00E;
  localparam logic [24:0] TC = 25'h155AA;

  initial begin
    for (int m = 0; m < 2; m++) begin
      ctx_valid[m] = 0; ctx_pid[m] = 0; req_valid[m] = 0; req_write[m] = 0;
      req_addr[m] = 0; req_wdata[m] = 0; rsp_ready[m] = 1;
      tr_cnt[m] = 0; wr_cnt[m] = 0; cur[m] = 0;
      for (int i = 0; i < NL; i++) begin mv[m][i] = 0; mt[m][i] = 0; mp[m][i] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R10", "req_ready after reset", 32'(req_ready[m]), 32'd1);
      chk("R10", "no response after reset", 32'(rsp_valid[m]), 32'd0);
      chk("R10", "no outbound after reset",
          32'({tr_req_valid[m], mem_rd_valid[m], mem_wr_valid[m]}), 32'd0);
    end
    for (int m = 0; m < 2; m++) begin
      // cold start with identifier zero
      for (int i = 0; i < 4; i++) access(m, 0, TA, i, i, 0, "R10", 0);
      for (int i = 0; i < 4; i++) access(m, 0, TA, i, (i + 1) % 4, 0, "R1", 0);
      // second identifier on the upper indices
      ctx(m, 8'h03, "R4");
      for (int i = 4; i < 8; i++) access(m, 0, TB, i, i % 4, 0, "R3", 0);
      for (int i = 4; i < 8; i++) access(m, 0, TB, i, 3 - i % 4, 0, "R3", 0);
      // back to zero: coexistence or compulsory misses
      ctx(m, 8'h00, "R4");
      for (int i = 0; i < 4; i++) access(m, 0, TA, i, i, 0, m == 1 ? "R5" : "R3", 0);
      ctx(m, 8'h00, "R4");
      for (int i = 0; i < 4; i++) access(m, 0, TA, i, 0, 0, "R4", 0);
      // tag conflict replaces the line
      access(m, 0, TC, 0, 1, 0, "R8", 0);
      access(m, 0, TA, 0, 1, 0, "R8", 0);
      // write hit then read back
      access(m, 1, TA, 1, 2, 32'hC0DE_0000 + 32'(m), "R6", 0);
      access(m, 0, TA, 1, 2, 0, "R6", 0);
      // write miss leaves resident line
      access(m, 1, TC, 2, 3, 32'hFEED_0000 + 32'(m), "R7", 0);
      access(m, 0, TA, 2, 3, 0, "R7", 0);
      access(m, 0, TC, 2, 3, 0, "R7", 0);
      // response back-pressure
      access(m, 0, TA, 3, 1, 0, "R9", 1);
      // sweep identifiers over all indices
      for (int p = 0; p < 4; p++) begin
        ctx(m, 8'(p), "R4");
        for (int i = 0; i < NL; i++) access(m, 0, (p % 2 == 1) ? TB : TA, i, i % 4, 0, "R3/R5", 0);
        for (int i = 0; i < NL; i++) access(m, 0, (p % 2 == 1) ? TB : TA, i, (i + 2) % 4, 0, "R1/R8", 0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule